// File: doc/BRIEF.md
# Strobe-Written Dual-Clock FIFO with Fill Thresholds and Parity

This block is a first-in first-out buffer between two clock domains. The writer does not use a plain enable. It drives two active-low lines: a write line and a block-select line. Their OR forms a write strobe. A word is committed when that strobe returns high after a period in which both lines were low. The data and parity present on that rising edge are the ones stored. Both lines are sampled on the write clock. The reader pops one word per read-clock cycle while its active-low read line is low and the buffer is not empty.

The write side reports when the buffer is full. It also reports two fill-level flags against a fixed threshold: one for a level exactly equal to the threshold, one for a level at or above it. A mode input chooses how parity is handled. The block can compute the parity bit itself, or it can store the caller's parity bit and report a mismatch on an error output. After a reset, the write line must fall once before any strobe is honoured. Pointers cross between clocks as Gray code through two-stage synchronizers.

Top module: `strobe_fifo`

## Requirements
- R1: A word is committed only on a write-clock edge where the sampled strobe (`wr_n` OR `sel_n`) is high and was low at the previous edge. Toggling `wr_n` while `sel_n` stays high stores nothing.
- R2: After write reset, strobes are ignored until `wr_n` has been sampled high and then low. A write line held low from reset does not count as a falling edge.
- R3: A strobe that arrives while `full` is high is ignored. The stored words and the write pointer are left unchanged.
- R4: Words are read out in the order they were written, across unrelated write and read clocks. `rdata` is updated on the read-clock edge that accepts the read.
- R5: `empty` is high out of reset. It falls a few read clocks after the first write and rises again after the last word is read. A read while `empty` is high leaves `rdata`, `rpar` and the read pointer unchanged.
- R6: `lvl_eq` is high exactly when the write-side fill level equals `THRESH`.
- R7: `lvl_ge` is high exactly when the write-side fill level is at or above `THRESH`. It is therefore always high while `lvl_eq` or `full` is high.
- R8: With `par_gen` high, the stored parity bit is the XOR of the data bits, the `wpar` input is ignored, and `par_err` is held low.
- R9: With `par_gen` low, the stored parity bit is `wpar`. `par_err` is updated on each committed word to (XOR of data bits) XOR `wpar`, and holds its value between words.
- R10: Synchronous reset gives `full`, `lvl_eq`, `lvl_ge` and `par_err` low in the write domain. It gives `empty` high and `rdata`/`rpar` zero in the read domain.
- R11: `full` is high exactly when `DEPTH` words are held on the write side. After a read frees an entry and the pointer has crossed over, `full` falls and the next strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_n | input | 1 | Active-low write line |
| sel_n | input | 1 | Active-low block-select line |
| wdata | input | DW | Write data |
| wpar | input | 1 | Incoming parity bit (used when `par_gen` is low) |
| par_gen | input | 1 | 1: compute parity internally, 0: check incoming parity |
| full | output | 1 | Buffer holds DEPTH words |
| lvl_eq | output | 1 | Fill level equals THRESH |
| lvl_ge | output | 1 | Fill level at or above THRESH |
| par_err | output | 1 | Parity mismatch on the last committed word |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_n | input | 1 | Active-low read request |
| rdata | output | DW | Read data |
| rpar | output | 1 | Stored parity bit of the last word read |
| empty | output | 1 | No word available to the reader |

## Verification
The hardest case to reach is the full buffer: a refused strobe, followed by a single read whose effect has to cross back into the write domain before the next strobe may land. The bench fills the buffer to `DEPTH` and checks the threshold flags after every write. It then sends one extra strobe and reads one word. It waits out the synchronizer delay and writes a marker word. Draining the whole buffer then shows that the marker sits in the last slot and the refused word appears nowhere. The unarmed state after reset is reached by holding the write line low through reset and pulsing only the select line.

// File: rtl/strobe_fifo_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the strobe FIFO.
// Assumes pointer widths of at most 32 bits.
package strobe_fifo_pkg;

    // Convert a Gray-coded value (zero-extended to 32 bits) to binary.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/strobe_fifo_sync.sv
`timescale 1ns/1ps
// Module: two-stage synchronizer for a Gray-coded pointer bus.
// Assumes the input changes by at most one bit between destination edges.
module strobe_fifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series, cleared by the destination reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/strobe_fifo_ram.sv
`timescale 1ns/1ps
// Module: storage array with one write port (write clock) and one
// registered read port (read clock).
// Assumes the controllers never write and read the same entry at once.
module strobe_fifo_ram #(
    parameter int WW    = 9,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wword,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rword
);
    logic [WW-1:0] mem [DEPTH];

    // Store the committed word.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wword;
    end

    // Register the word being popped; hold it otherwise.
    always_ff @(posedge rclk) begin
        if (!rrst_n)  rword <= '0;
        else if (re)  rword <= mem[raddr];
    end
endmodule

// File: rtl/strobe_fifo_wctl.sv
`timescale 1ns/1ps
// Module: write-side control. Detects the rising edge of the combined
// strobe, arms after the first falling edge of the write line, forms the
// parity bit, advances the write pointer and registers full and threshold
// flags.
// Assumes wr_n and sel_n are synchronous to wclk, and 1 <= THRESH <= DEPTH.
module strobe_fifo_wctl #(
    parameter int DW     = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 5,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_n,
    input  logic          sel_n,
    input  logic [DW-1:0] wdata,
    input  logic          wpar,
    input  logic          par_gen,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW:0]   wword,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          lvl_eq,
    output logic          lvl_ge,
    output logic          par_err
);
    import strobe_fifo_pkg::*;

    localparam logic [AW:0] THR_V  = THRESH[AW:0];
    localparam logic [AW:0] FULL_V = DEPTH[AW:0];

    logic        strb, strb_q, wr_q, armed_q, rise, calc_par;
    logic [AW:0] wbin, wbin_nxt, rbin_s, level_nxt;
    logic [31:0] rbin_wide;

    assign strb     = wr_n | sel_n;
    assign rise     = strb & ~strb_q;
    assign we       = rise & armed_q & ~full;
    assign calc_par = ^wdata;
    assign wword    = {(par_gen ? calc_par : wpar), wdata};
    assign waddr    = wbin[AW-1:0];

    assign wbin_nxt  = wbin + {{AW{1'b0}}, we};
    assign rbin_wide = gray_to_bin(32'(rgray_s));
    assign rbin_s    = rbin_wide[AW:0];
    assign level_nxt = wbin_nxt - rbin_s;

    // Remember last sampled strobe and write line for edge detection.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            strb_q <= 1'b1;
            wr_q   <= 1'b0;
        end else begin
            strb_q <= strb;
            wr_q   <= wr_n;
        end
    end

    // Arm once the write line has fallen after reset.
    always_ff @(posedge wclk) begin
        if (!wrst_n)             armed_q <= 1'b0;
        else if (wr_q && !wr_n)  armed_q <= 1'b1;
    end

    // Advance the write pointer in binary and Gray form.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Register full and threshold flags from the next fill level.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            full   <= 1'b0;
            lvl_eq <= 1'b0;
            lvl_ge <= 1'b0;
        end else begin
            full   <= (level_nxt == FULL_V);
            lvl_eq <= (level_nxt == THR_V);
            lvl_ge <= (level_nxt >= THR_V);
        end
    end

    // Parity error: cleared in generate mode, updated per committed word.
    always_ff @(posedge wclk) begin
        if (!wrst_n)      par_err <= 1'b0;
        else if (par_gen) par_err <= 1'b0;
        else if (we)      par_err <= calc_par ^ wpar;
    end
endmodule

// File: rtl/strobe_fifo_rctl.sv
`timescale 1ns/1ps
// Module: read-side control. Accepts a read while not empty, advances the
// read pointer and registers the empty flag.
// Assumes rd_n is synchronous to rclk.
module strobe_fifo_rctl #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_n,
    input  logic [AW:0]   wgray_s,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty
);
    logic [AW:0] rbin, rbin_nxt, rgray_nxt;

    assign re        = ~rd_n & ~empty;
    assign raddr     = rbin[AW-1:0];
    assign rbin_nxt  = rbin + {{AW{1'b0}}, re};
    assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);

    // Advance the read pointer and register the empty flag.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rgray_nxt;
            empty <= (rgray_nxt == wgray_s);
        end
    end
endmodule

// File: rtl/strobe_fifo.sv
`timescale 1ns/1ps
// Module: dual-clock FIFO written by a combined active-low strobe, with
// full/empty, two threshold flags and selectable parity handling.
// Assumes DEPTH is a power of two (>= 2) and 1 <= THRESH <= DEPTH.
module strobe_fifo #(
    parameter int DW     = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 5,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_n,
    input  logic          sel_n,
    input  logic [DW-1:0] wdata,
    input  logic          wpar,
    input  logic          par_gen,
    output logic          full,
    output logic          lvl_eq,
    output logic          lvl_ge,
    output logic          par_err,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_n,
    output logic [DW-1:0] rdata,
    output logic          rpar,
    output logic          empty
);
    logic          we, re;
    logic [AW-1:0] waddr, raddr;
    logic [DW:0]   wword, rword;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

    assign rdata = rword[DW-1:0];
    assign rpar  = rword[DW];

    strobe_fifo_wctl #(.DW(DW), .DEPTH(DEPTH), .THRESH(THRESH)) u_wctl (
        .wclk(wclk), .wrst_n(wrst_n), .wr_n(wr_n), .sel_n(sel_n),
        .wdata(wdata), .wpar(wpar), .par_gen(par_gen), .rgray_s(rgray_s),
        .we(we), .waddr(waddr), .wword(wword), .wgray(wgray),
        .full(full), .lvl_eq(lvl_eq), .lvl_ge(lvl_ge), .par_err(par_err)
    );

    strobe_fifo_rctl #(.DEPTH(DEPTH)) u_rctl (
        .rclk(rclk), .rrst_n(rrst_n), .rd_n(rd_n), .wgray_s(wgray_s),
        .re(re), .raddr(raddr), .rgray(rgray), .empty(empty)
    );

    strobe_fifo_sync #(.W(AW+1)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    strobe_fifo_sync #(.W(AW+1)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    strobe_fifo_ram #(.WW(DW+1), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wword(wword),
        .rclk(rclk), .rrst_n(rrst_n), .re(re), .raddr(raddr), .rword(rword)
    );
endmodule

// File: rtl/strobe_fifo_chk.sv
`timescale 1ns/1ps
// Module: property checker for strobe_fifo, attached by bind.
// Assumes both resets are held low for at least two edges of their clock.
module strobe_fifo_chk #(
    parameter int AW = 3
) (
    input logic        wclk,
    input logic        wrst_n,
    input logic        rclk,
    input logic        rrst_n,
    input logic        full,
    input logic        empty,
    input logic        lvl_eq,
    input logic        lvl_ge,
    input logic        par_err,
    input logic        par_gen,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray
);
    a_r3_full_blocks_write: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |=> $stable(wgray));

    a_r5_empty_blocks_read: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |=> $stable(rgray));

    a_r7_eq_implies_ge: assert property (@(posedge wclk) disable iff (!wrst_n)
        lvl_eq |-> lvl_ge);

    a_r7_full_implies_ge: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |-> lvl_ge);

    a_r8_gen_clears_err: assert property (@(posedge wclk) disable iff (!wrst_n)
        par_gen |=> !par_err);

    a_r1_wptr_one_step: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r10_wr_reset_vals: assert property (@(posedge wclk)
        !wrst_n |=> (!full && !lvl_eq && !lvl_ge && !par_err));

    a_r10_rd_reset_empty: assert property (@(posedge rclk)
        !rrst_n |=> empty);
endmodule

bind strobe_fifo strobe_fifo_chk #(.AW(AW)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .full(full), .empty(empty), .lvl_eq(lvl_eq), .lvl_ge(lvl_ge),
    .par_err(par_err), .par_gen(par_gen), .wgray(wgray), .rgray(rgray)
);

// File: tb/strobe_fifo_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checking at the ports.
module strobe_fifo_tb;
    localparam int DW = 8, DEPTH = 8, THRESH = 5;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wrst_n = 1'b0, rrst_n = 1'b0;
    logic wr_n = 1'b0, sel_n = 1'b1, wpar = 1'b0, par_gen = 1'b1, rd_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic full, lvl_eq, lvl_ge, par_err, rpar, empty;
    logic [DW-1:0] rdata;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [DW-1:0] model [64];
    int head = 0, tail = 0;

    always #2 wclk = ~wclk;
    always #3 rclk = ~rclk;

    strobe_fifo #(.DW(DW), .DEPTH(DEPTH), .THRESH(THRESH)) u_dut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_n(wr_n), .sel_n(sel_n),
        .wdata(wdata), .wpar(wpar), .par_gen(par_gen), .full(full),
        .lvl_eq(lvl_eq), .lvl_ge(lvl_ge), .par_err(par_err),
        .rclk(rclk), .rrst_n(rrst_n), .rd_n(rd_n), .rdata(rdata),
        .rpar(rpar), .empty(empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wwait(input int n);
        for (int i = 0; i < n; i++) @(negedge wclk);
    endtask

    task automatic rwait(input int n);
        for (int i = 0; i < n; i++) @(negedge rclk);
    endtask

    // One full strobe: both lines low, then write line high, then select high.
    task automatic do_write(input logic [DW-1:0] d, input logic p);
        @(negedge wclk);
        wdata = d; wpar = p; wr_n = 1'b0; sel_n = 1'b0;
        @(negedge wclk);
        wr_n = 1'b1;
        @(negedge wclk);
        sel_n = 1'b1;
        @(negedge wclk);
    endtask

    task automatic do_read();
        @(negedge rclk);
        rd_n = 1'b0;
        @(negedge rclk);
        rd_n = 1'b1;
    endtask

    task automatic t_reset();
        wwait(5); rwait(5);
        chk("R10 full", full, 0);
        chk("R10 lvl_eq", lvl_eq, 0);
        chk("R10 lvl_ge", lvl_ge, 0);
        chk("R10 par_err", par_err, 0);
        chk("R10 empty", empty, 1);
        chk("R10 rdata", {rpar, rdata}, 0);
        @(negedge wclk); wrst_n = 1'b1;
        @(negedge rclk); rrst_n = 1'b1;
    endtask

    // R2: write line held low since reset; only select pulses.
    task automatic t_unarmed();
        for (int k = 0; k < 3; k++) begin
            @(negedge wclk); wdata = 8'h5A; sel_n = 1'b0;
            wwait(2); sel_n = 1'b1;
            wwait(1);
        end
        rwait(12);
        chk("R2 empty while unarmed", empty, 1);
        chk("R2 lvl_ge while unarmed", lvl_ge, 0);
    endtask

    // R1: write line toggles with select high; this also arms the port.
    task automatic t_select_gate();
        @(negedge wclk); wr_n = 1'b1;
        wwait(2); wr_n = 1'b0;
        wwait(2); wr_n = 1'b1;
        rwait(12);
        chk("R1 no write without select", empty, 1);
    endtask

    task automatic t_fill();
        for (int n = 1; n <= DEPTH; n++) begin
            logic [DW-1:0] d;
            d = DW'((n * 37 + 5) & 255);
            do_write(d, 1'b0);
            model[tail] = d; tail++;
            wwait(1);
            chk("R6 lvl_eq", lvl_eq, (n == THRESH) ? 1 : 0);
            chk("R7 lvl_ge", lvl_ge, (n >= THRESH) ? 1 : 0);
            chk("R11 full", full, (n == DEPTH) ? 1 : 0);
            chk("R8 par_err low in gen mode", par_err, 0);
        end
        rwait(8);
        chk("R5 empty falls", empty, 0);
    endtask

    task automatic t_full_block();
        do_write(8'hEE, 1'b0);
        wwait(2);
        chk("R3 still full", full, 1);
        chk("R3 lvl_eq unchanged", lvl_eq, 0);
    endtask

    task automatic t_full_release();
        logic [DW-1:0] e;
        do_read();
        e = model[head]; head++;
        chk("R4 first word", rdata, e);
        chk("R8 generated parity", rpar, ^e);
        wwait(8);
        chk("R11 full clears after read", full, 0);
        chk("R7 level below full", lvl_ge, 1);
        do_write(8'h77, 1'b0);
        model[tail] = 8'h77; tail++;
        wwait(1);
        chk("R11 write after release", full, 1);
    endtask

    task automatic t_drain();
        logic [DW:0] last;
        while (head < tail) begin
            logic [DW-1:0] e;
            do_read();
            e = model[head]; head++;
            chk("R4 order", rdata, e);
        end
        rwait(2);
        chk("R5 empty after drain", empty, 1);
        last = {rpar, rdata};
        do_read();
        rwait(1);
        chk("R5 read while empty ignored", {rpar, rdata}, last);
        chk("R3 refused word absent", rdata, 8'h77);
        wwait(6);
        chk("R7 level zero", lvl_ge, 0);
    endtask

    task automatic t_parity();
        @(negedge wclk); par_gen = 1'b0;
        do_write(8'h03, 1'b1);
        wwait(1);
        chk("R9 mismatch flagged", par_err, 1);
        rwait(8);
        do_read();
        chk("R9 stored incoming parity", rpar, 1);
        chk("R9 data", rdata, 8'h03);
        wwait(3);
        chk("R9 error holds between words", par_err, 1);
        do_write(8'h01, 1'b1);
        wwait(1);
        chk("R9 match clears", par_err, 0);
        rwait(8);
        do_read();
        chk("R9 matching parity stored", rpar, 1);
        @(negedge wclk); par_gen = 1'b1;
        do_write(8'h07, 1'b0);
        wwait(1);
        chk("R8 err low in gen mode", par_err, 0);
        rwait(8);
        do_read();
        chk("R8 wpar ignored, parity computed", rpar, 1);
        chk("R8 data", rdata, 8'h07);
    endtask

    initial begin
        t_reset();
        t_unarmed();
        t_select_gate();
        t_fill();
        t_full_block();
        t_full_release();
        t_drain();
        t_parity();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule